// File: doc/BRIEF.md
# FFT Pass Sequencer and Address Generator

This block walks a transform datapath through the passes of one function chosen by the host. The three functions are analysis windowing plus forward FFT, inverse FFT plus synthesis windowing, and gain application. A start strobe carries the function number and the transform configuration: log2 of the FFT size N and log2 of the window length L. The block latches that configuration. In its first fetch cycle it reads the function-level settings, including the pass count. Before each pass it fetches one microcode word, which holds the opcode, the width of the bit-reversed address field, the element count and the radix. The word stays fixed for the whole pass.

During a pass, one binary element counter drives all outputs. The operation index sent to the datapath is the counter with its radix bits dropped. The data address is the counter with its low bits reversed. The coefficient address is the operation index with its low bits reversed. Data is updated in place, so the read address and the write address are the same value. Arithmetic is left to the datapath.

Commands leave on a valid/ready stream. A command is taken on a cycle where `cmd_valid` and `cmd_ready` are both high. While `cmd_ready` is low the command is held unchanged, and the sequencer waits without limit. `cmd_valid` does not depend on `cmd_ready`. Start, busy and done are plain level and pulse pins.

Top module: `fft_pass_sequencer`

## Requirements
- R1: While reset is active, and afterwards until a start is accepted, `busy`, `cmd_valid`, `cmd_last` and `done` are low.
- R2: A start with `func_sel` 0, 1 or 2 in an idle cycle is accepted: `busy` is high after that edge, `cmd_valid` stays low for two fetch cycles, and the first command is valid on the third cycle after the accepting edge.
- R3: A start with `func_sel` = 3 is ignored: `busy` and `cmd_valid` stay low.
- R4: `func_sel`, `cfg_log2n` and `cfg_log2l` are sampled only when a start is accepted. A start, or a configuration change, while `busy` is high does not alter the running sequence and does not cause a second run.
- R5: Opcodes are 0 analysis window, 1 forward radix-4, 2 forward radix-2, 3 inverse radix-4, 4 inverse radix-2, 5 synthesis window, 6 gain. Function 0 runs the analysis window and then P forward passes. Function 1 runs P inverse passes and then the synthesis window. Function 2 runs a single gain pass.
- R6: P = ceil(log2N / 2), and FFT pass j counts 0..P-1. When log2N is odd, the last FFT pass is radix-2. Every other FFT pass is radix-4. `cmd_pass` gives the pass index within the function.
- R7: A window pass has L elements, a gain pass has N/2 elements and an FFT pass has N elements. Each is issued in element order e = 0,1,... The operation index is e>>2 for a radix-4 pass, e>>1 for a radix-2 pass and e for any other pass.
- R8: The data address is e with its low k bits reversed and the bits above them kept. k = log2N - 2j for FFT pass j, and k = 0 for window and gain passes.
- R9: The coefficient address is the operation index with its low (k - r) bits reversed, where r is 2 for radix-4, 1 for radix-2 and 0 otherwise.
- R10: While `cmd_valid` is high and `cmd_ready` is low, every command field holds its value. The element counter advances only on a handshake.
- R11: Between two passes of one function, `cmd_valid` is low for exactly one cycle.
- R12: `cmd_last` is high only on the final element of the final pass. `done` is a one-cycle pulse in the cycle after that element's handshake, and in the same cycle `busy` is low.
- R13: `cfg_log2n` is clamped to [3, MAX_LOG2N]. `cfg_log2l` is clamped to [MIN_LOG2L, MAX_LOG2L].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe for a function |
| func_sel | input | 2 | Function number sampled with start |
| cfg_log2n | input | 4 | log2 of FFT size N |
| cfg_log2l | input | 4 | log2 of window length L |
| cmd_valid | output | 1 | Command available |
| cmd_ready | input | 1 | Datapath accepts the command |
| cmd_opcode | output | 3 | Pass operation code |
| cmd_pass | output | 3 | Pass index within the function |
| cmd_op_idx | output | 8 | Operation counter for the datapath |
| cmd_data_addr | output | 8 | Data read/write address (in place) |
| cmd_coef_addr | output | 8 | Coefficient address |
| cmd_last | output | 1 | Final element of the function |
| busy | output | 1 | A function is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench aims at the following corner cases and the failure each one exposes.

- **Odd log2N (N = 8, 32, 128).** These sizes need a radix-2 tail pass. A wrong radix rule would show up as a radix-4 opcode, or as coefficient addresses that use the wrong reversed width.
- **Clamping (R13).** Configurations outside the legal range are applied. A design that does not clamp would issue far too few or too many elements.
- **Starts and configuration changes during a run.** These are injected while `busy` is high. A design that does not ignore them would restart, jump to a different function or change its address width mid-run.
- **Random back-pressure.** It stresses command holding and the one-cycle bubble between passes. A slip in either would skip or repeat an address, or would raise `done` one cycle early or late.

// File: rtl/fps_pkg.sv
package fps_pkg;

  localparam int LOG_W = 4;

  typedef enum logic [2:0] {
    OP_AN_WIN  = 3'd0,
    OP_FFT_R4  = 3'd1,
    OP_FFT_R2  = 3'd2,
    OP_IFFT_R4 = 3'd3,
    OP_IFFT_R2 = 3'd4,
    OP_SYN_WIN = 3'd5,
    OP_GAIN    = 3'd6
  } op_e;

  typedef enum logic [1:0] {
    FN_ANALYSIS = 2'd0,
    FN_SYNTH    = 2'd1,
    FN_GAIN     = 2'd2,
    FN_RSVD     = 2'd3
  } func_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_CFG   = 2'd1,
    S_UCODE = 2'd2,
    S_RUN   = 2'd3
  } seq_state_e;

  // One microcode word: fixed for a whole pass.
  typedef struct packed {
    op_e              op;
    logic [LOG_W-1:0] rev_bits;   // width of reversed data-address field
    logic [LOG_W-1:0] cnt_log2;   // log2 of element count
    logic [1:0]       rad_log;    // element bits per operation
  } uword_t;

  function automatic uword_t mk_word(op_e op, logic [LOG_W-1:0] rev,
                                     logic [LOG_W-1:0] cnt, logic [1:0] rad);
    uword_t w;
    w.op       = op;
    w.rev_bits = rev;
    w.cnt_log2 = cnt;
    w.rad_log  = rad;
    return w;
  endfunction

endpackage

// File: rtl/fps_ucode_rom.sv
module fps_ucode_rom
  import fps_pkg::*;
#(
  parameter int PASS_W = 3
) (
  input  logic [1:0]        func,
  input  logic [LOG_W-1:0]  log2n,
  input  logic [LOG_W-1:0]  log2l,
  input  logic [PASS_W-1:0] pass,
  output logic [PASS_W-1:0] npass,
  output uword_t            word
);

  logic [LOG_W-1:0] fft_passes;
  logic [LOG_W-1:0] pass_ext;

  function automatic uword_t fft_word(logic [LOG_W-1:0] l2n, logic [LOG_W-1:0] j,
                                      logic [LOG_W-1:0] np, logic inv);
    logic tail_r2;
    op_e  op;
    tail_r2 = (j == np - LOG_W'(1)) && l2n[0];
    if (inv) op = tail_r2 ? OP_IFFT_R2 : OP_IFFT_R4;
    else     op = tail_r2 ? OP_FFT_R2  : OP_FFT_R4;
    return mk_word(op, l2n - (j << 1), l2n, tail_r2 ? 2'd1 : 2'd2);
  endfunction

  always_comb begin
    fft_passes = (log2n + LOG_W'(1)) >> 1;
    pass_ext   = LOG_W'(pass);
    npass      = PASS_W'(fft_passes + LOG_W'(1));
    word       = mk_word(OP_GAIN, '0, log2n - LOG_W'(1), 2'd0);
    case (func_e'(func))
      FN_ANALYSIS: begin
        if (pass_ext == '0) word = mk_word(OP_AN_WIN, '0, log2l, 2'd0);
        else                word = fft_word(log2n, pass_ext - LOG_W'(1), fft_passes, 1'b0);
      end
      FN_SYNTH: begin
        if (pass_ext == fft_passes) word = mk_word(OP_SYN_WIN, '0, log2l, 2'd0);
        else                        word = fft_word(log2n, pass_ext, fft_passes, 1'b1);
      end
      default: begin
        npass = PASS_W'(1);
      end
    endcase
  end

endmodule

// File: rtl/fps_bitrev.sv
module fps_bitrev #(
  parameter int W     = 8,
  parameter int SEL_W = 4
) (
  input  logic [W-1:0]     din,
  input  logic [SEL_W-1:0] nbits,
  output logic [W-1:0]     dout
);

  // cand[k] = din with its low k bits mirrored
  logic [W:0][W-1:0] cand;

  for (genvar k = 0; k <= W; k++) begin : g_width
    for (genvar i = 0; i < W; i++) begin : g_bit
      if (i < k) begin : g_rev
        assign cand[k][i] = din[k-1-i];
      end else begin : g_keep
        assign cand[k][i] = din[i];
      end
    end
  end

  always_comb begin
    dout = cand[W];
    for (int k = 0; k <= W; k++) begin
      if (int'(nbits) == k) dout = cand[k];
    end
  end

endmodule

// File: rtl/fps_addr_gen.sv
module fps_addr_gen
  import fps_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] elem,
  input  uword_t       word,
  output logic [W-1:0] op_idx,
  output logic [W-1:0] data_addr,
  output logic [W-1:0] coef_addr
);

  logic [LOG_W-1:0] coef_bits;

  assign op_idx    = elem >> word.rad_log;
  assign coef_bits = word.rev_bits - LOG_W'(word.rad_log);

  fps_bitrev #(.W(W), .SEL_W(LOG_W)) u_data_rev (
    .din   (elem),
    .nbits (word.rev_bits),
    .dout  (data_addr)
  );

  fps_bitrev #(.W(W), .SEL_W(LOG_W)) u_coef_rev (
    .din   (op_idx),
    .nbits (coef_bits),
    .dout  (coef_addr)
  );

endmodule

// File: rtl/fps_pass_ctrl.sv
module fps_pass_ctrl
  import fps_pkg::*;
#(
  parameter int MAX_LOG2N = 8,
  parameter int MAX_LOG2L = 8,
  parameter int MIN_LOG2L = 3,
  parameter int W         = 8,
  parameter int PASS_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        func_sel,
  input  logic [LOG_W-1:0]  cfg_log2n,
  input  logic [LOG_W-1:0]  cfg_log2l,
  input  logic              cmd_ready,
  input  logic [PASS_W-1:0] rom_npass,
  input  uword_t            rom_word,
  output logic [1:0]        func_q,
  output logic [LOG_W-1:0]  l2n_q,
  output logic [LOG_W-1:0]  l2l_q,
  output logic [PASS_W-1:0] pass_q,
  output uword_t            word_q,
  output logic [W-1:0]      elem_q,
  output logic              run,
  output logic              last,
  output logic              busy,
  output logic              done
);

  localparam logic [LOG_W-1:0] N_LO = LOG_W'(3);
  localparam logic [LOG_W-1:0] N_HI = LOG_W'(MAX_LOG2N);
  localparam logic [LOG_W-1:0] L_LO = LOG_W'(MIN_LOG2L);
  localparam logic [LOG_W-1:0] L_HI = LOG_W'(MAX_LOG2L);

  seq_state_e        state;
  logic [PASS_W-1:0] npass_q;
  logic              done_q;
  logic [W:0]        span;
  logic              elem_end;
  logic              pass_final;
  logic              accept;

  function automatic logic [LOG_W-1:0] clamp(logic [LOG_W-1:0] v, logic [LOG_W-1:0] lo,
                                             logic [LOG_W-1:0] hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  assign span       = ((W+1)'(1) << word_q.cnt_log2) - (W+1)'(1);
  assign elem_end   = ({1'b0, elem_q} == span);
  assign pass_final = (pass_q == npass_q - PASS_W'(1));
  assign accept     = start && (func_sel != FN_RSVD);

  assign run  = (state == S_RUN);
  assign last = run && elem_end && pass_final;
  assign busy = (state != S_IDLE);
  assign done = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      func_q  <= '0;
      l2n_q   <= N_LO;
      l2l_q   <= L_LO;
      npass_q <= '0;
      pass_q  <= '0;
      word_q  <= '0;
      elem_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: begin
          if (accept) begin
            func_q <= func_sel;
            l2n_q  <= clamp(cfg_log2n, N_LO, N_HI);
            l2l_q  <= clamp(cfg_log2l, L_LO, L_HI);
            state  <= S_CFG;
          end
        end
        S_CFG: begin
          npass_q <= rom_npass;
          pass_q  <= '0;
          state   <= S_UCODE;
        end
        S_UCODE: begin
          word_q <= rom_word;
          elem_q <= '0;
          state  <= S_RUN;
        end
        S_RUN: begin
          if (cmd_ready) begin
            if (!elem_end) begin
              elem_q <= elem_q + W'(1);
            end else if (pass_final) begin
              state  <= S_IDLE;
              done_q <= 1'b1;
            end else begin
              pass_q <= pass_q + PASS_W'(1);
              state  <= S_UCODE;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fft_pass_sequencer.sv
module fft_pass_sequencer
  import fps_pkg::*;
#(
  parameter  int MAX_LOG2N = 8,
  parameter  int MAX_LOG2L = 8,
  parameter  int MIN_LOG2L = 3,
  localparam int ADDR_W    = (MAX_LOG2N > MAX_LOG2L) ? MAX_LOG2N : MAX_LOG2L,
  localparam int PASS_W    = $clog2((MAX_LOG2N + 1) / 2 + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        func_sel,
  input  logic [LOG_W-1:0]  cfg_log2n,
  input  logic [LOG_W-1:0]  cfg_log2l,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [2:0]        cmd_opcode,
  output logic [PASS_W-1:0] cmd_pass,
  output logic [ADDR_W-1:0] cmd_op_idx,
  output logic [ADDR_W-1:0] cmd_data_addr,
  output logic [ADDR_W-1:0] cmd_coef_addr,
  output logic              cmd_last,
  output logic              busy,
  output logic              done
);

  logic [1:0]        func_q;
  logic [LOG_W-1:0]  l2n_q;
  logic [LOG_W-1:0]  l2l_q;
  logic [PASS_W-1:0] pass_q;
  logic [PASS_W-1:0] rom_npass;
  uword_t            rom_word;
  uword_t            word_q;
  logic [ADDR_W-1:0] elem_q;

  fps_ucode_rom #(.PASS_W(PASS_W)) u_rom (
    .func  (func_q),
    .log2n (l2n_q),
    .log2l (l2l_q),
    .pass  (pass_q),
    .npass (rom_npass),
    .word  (rom_word)
  );

  fps_pass_ctrl #(
    .MAX_LOG2N (MAX_LOG2N),
    .MAX_LOG2L (MAX_LOG2L),
    .MIN_LOG2L (MIN_LOG2L),
    .W         (ADDR_W),
    .PASS_W    (PASS_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .func_sel  (func_sel),
    .cfg_log2n (cfg_log2n),
    .cfg_log2l (cfg_log2l),
    .cmd_ready (cmd_ready),
    .rom_npass (rom_npass),
    .rom_word  (rom_word),
    .func_q    (func_q),
    .l2n_q     (l2n_q),
    .l2l_q     (l2l_q),
    .pass_q    (pass_q),
    .word_q    (word_q),
    .elem_q    (elem_q),
    .run       (cmd_valid),
    .last      (cmd_last),
    .busy      (busy),
    .done      (done)
  );

  fps_addr_gen #(.W(ADDR_W)) u_agen (
    .elem      (elem_q),
    .word      (word_q),
    .op_idx    (cmd_op_idx),
    .data_addr (cmd_data_addr),
    .coef_addr (cmd_coef_addr)
  );

  assign cmd_opcode = word_q.op;
  assign cmd_pass   = pass_q;

endmodule

// File: rtl/fft_pass_sequencer_chk.sv
module fft_pass_sequencer_chk #(
  parameter int AW = 8,
  parameter int PW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [1:0]    func_sel,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [2:0]    cmd_opcode,
  input logic [PW-1:0] cmd_pass,
  input logic [AW-1:0] cmd_op_idx,
  input logic [AW-1:0] cmd_data_addr,
  input logic [AW-1:0] cmd_coef_addr,
  input logic          cmd_last,
  input logic          busy,
  input logic          done
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!cmd_valid && !cmd_last));

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && func_sel != 2'd3) |=> (busy && !cmd_valid));

  p_rsvd_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && func_sel == 2'd3) |=> !busy);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_opcode) && $stable(cmd_pass)
      && $stable(cmd_op_idx) && $stable(cmd_data_addr) && $stable(cmd_coef_addr)));

  p_bubble_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cmd_valid) && busy) |=> cmd_valid);

  p_pass_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !cmd_last) |=>
      ((cmd_valid && cmd_pass == $past(cmd_pass)) || (!cmd_valid && busy)));

  p_done_after_last_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_last) |=> (done && !busy));

  p_done_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind fft_pass_sequencer fft_pass_sequencer_chk #(.AW(ADDR_W), .PW(PASS_W)) i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start         (start),
  .func_sel      (func_sel),
  .cmd_valid     (cmd_valid),
  .cmd_ready     (cmd_ready),
  .cmd_opcode    (cmd_opcode),
  .cmd_pass      (cmd_pass),
  .cmd_op_idx    (cmd_op_idx),
  .cmd_data_addr (cmd_data_addr),
  .cmd_coef_addr (cmd_coef_addr),
  .cmd_last      (cmd_last),
  .busy          (busy),
  .done          (done)
);

// File: tb/test_fft_pass_sequencer.sv
`timescale 1ns/1ps
module test_fft_pass_sequencer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [1:0] func_sel = 2'd0;
  logic [3:0] cfg_log2n = 4'd3;
  logic [3:0] cfg_log2l = 4'd3;
  logic       cmd_ready = 1'b0;
  logic       cmd_valid;
  logic [2:0] cmd_opcode;
  logic [2:0] cmd_pass;
  logic [7:0] cmd_op_idx;
  logic [7:0] cmd_data_addr;
  logic [7:0] cmd_coef_addr;
  logic       cmd_last;
  logic       busy;
  logic       done;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  fft_pass_sequencer i_fft_pass_sequencer (
    .clk(clk), .rst_n(rst_n), .start(start), .func_sel(func_sel),
    .cfg_log2n(cfg_log2n), .cfg_log2l(cfg_log2l),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_opcode(cmd_opcode),
    .cmd_pass(cmd_pass), .cmd_op_idx(cmd_op_idx), .cmd_data_addr(cmd_data_addr),
    .cmd_coef_addr(cmd_coef_addr), .cmd_last(cmd_last), .busy(busy), .done(done)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int b_clamp(input int v, input int lo, input int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  function automatic int b_npass(input int f, input int cn);
    if (f == 2) return 1;
    return (cn + 1) / 2 + 1;
  endfunction

  function automatic int b_rev(input int x, input int n);
    int r;
    r = x;
    for (int i = 0; i < n; i++) r[i] = x[n-1-i];
    return r;
  endfunction

  function automatic void b_word(input int f, input int cn, input int cl, input int p,
                                 output int op, output int rev, output int cnt, output int rad);
    int  np;
    int  j;
    bit  inv;
    bit  r2;
    np = (cn + 1) / 2;
    if (f == 2) begin op = 6; rev = 0; cnt = cn - 1; rad = 0; return; end
    if (f == 0) begin
      if (p == 0) begin op = 0; rev = 0; cnt = cl; rad = 0; return; end
      j = p - 1; inv = 1'b0;
    end else begin
      if (p == np) begin op = 5; rev = 0; cnt = cl; rad = 0; return; end
      j = p; inv = 1'b1;
    end
    r2  = (j == np - 1) && (cn % 2 == 1);
    op  = inv ? (r2 ? 4 : 3) : (r2 ? 2 : 1);
    rev = cn - 2 * j;
    cnt = cn;
    rad = r2 ? 1 : 2;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_job(input int f, input int l2n, input int l2l, input int pct, input bit disturb);
    int  cn, cl, np;
    int  op, rev, cnt, rad;
    bit  abort;
    cn = b_clamp(l2n, 3, 8);
    cl = b_clamp(l2l, 3, 8);
    np = b_npass(f, cn);
    abort = 1'b0;
    @(negedge clk);
    start = 1'b1; func_sel = 2'(f); cfg_log2n = 4'(l2n); cfg_log2l = 4'(l2l);
    @(negedge clk);
    start = 1'b0;
    chk("R2 busy after accepted start", int'(busy), 1);
    @(negedge clk);
    chk("R2 no command during fetch", int'(cmd_valid), 0);
    @(negedge clk);
    for (int p = 0; p < np && !abort; p++) begin
      b_word(f, cn, cl, p, op, rev, cnt, rad);
      for (int e = 0; e < (1 << cnt) && !abort; e++) begin
        bit took;
        int stalls;
        took = 1'b0;
        stalls = 0;
        while (!took) begin
          string pre;
          pre = (stalls > 0) ? "R10 held " : "";
          if (!cmd_valid) begin
            chk("R11 command valid inside pass", 0, 1);
            abort = 1'b1;
            break;
          end
          chk({pre, "R5 R6 opcode"}, int'(cmd_opcode), op);
          chk({pre, "R6 pass index"}, int'(cmd_pass), p);
          chk({pre, "R7 op index"}, int'(cmd_op_idx), e >> rad);
          chk({pre, "R8 data address"}, int'(cmd_data_addr), b_rev(e, rev));
          chk({pre, "R9 coef address"}, int'(cmd_coef_addr), b_rev(e >> rad, rev - rad));
          chk({pre, "R12 last flag"}, int'(cmd_last),
              int'(p == np - 1 && e == (1 << cnt) - 1));
          took = (($urandom % 100) < 32'(pct)) || (stalls >= 4);
          if (disturb && p == ((np > 1) ? 1 : 0) && e == 1 && stalls == 0) begin
            // R4: start and new configuration while busy
            start = 1'b1;
            func_sel = 2'((f + 1) % 3);
            cfg_log2n = (cn == 8) ? 4'd4 : 4'd8;
            cfg_log2l = (cl == 8) ? 4'd3 : 4'd8;
          end
          cmd_ready = took;
          @(negedge clk);
          cmd_ready = 1'b0;
          start = 1'b0;
          if (!took) stalls++;
        end
      end
      if (!abort && p < np - 1) begin
        chk("R11 bubble between passes", int'(cmd_valid), 0);
        @(negedge clk);
      end
    end
    if (abort) begin
      do_reset();
      return;
    end
    chk("R12 done pulse after last", int'(done), 1);
    chk("R12 busy low with done", int'(busy), 0);
    @(negedge clk);
    chk("R12 done lasts one cycle", int'(done), 0);
    chk("R4 no second run", int'(busy), 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (2) @(negedge clk);
    chk("R1 busy in reset", int'(busy), 0);
    chk("R1 valid in reset", int'(cmd_valid), 0);
    chk("R1 done in reset", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", int'(busy), 0);

    // R3: reserved function
    start = 1'b1; func_sel = 2'd3;
    @(negedge clk);
    start = 1'b0;
    chk("R3 reserved start ignored busy", int'(busy), 0);
    @(negedge clk);
    chk("R3 reserved start no command", int'(cmd_valid), 0);
    @(negedge clk);
    chk("R3 still idle", int'(busy), 0);

    run_job(0, 3, 5, 100, 1'b0);   // N=8 analysis: radix-4 then radix-2
    run_job(1, 3, 3, 60, 1'b1);    // N=8 synthesis with disturbance
    run_job(2, 5, 5, 50, 1'b1);    // gain
    run_job(0, 8, 8, 70, 1'b1);    // largest size
    run_job(1, 4, 6, 80, 1'b0);    // even log2N
    run_job(0, 7, 4, 60, 1'b0);    // odd log2N radix-2 tail
    run_job(2, 1, 3, 100, 1'b0);   // R13 clamp N up
    run_job(0, 15, 2, 100, 1'b0);  // R13 clamp N down, L up
    for (int k = 0; k < 8; k++) begin
      run_job(int'($urandom % 3), 3 + int'($urandom % 6), 3 + int'($urandom % 6),
              30 + int'($urandom % 71), bit'($urandom % 2));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    fails++;
    $display("FAIL R12 watchdog: cycles actual=%0d expected<=%0d", cyc, 150000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule